// File: doc/BRIEF.md
# Burst-Counter Dual-Port Synchronous RAM

This block is a shared memory reachable from two independent ports, each clocked by its own clock. Either port may read or write any word, and both may work at the same moment. Every port registers its request (enables, write flag, address-register operation and write data) on its rising clock edge. The word it then touches is named by a per-port address register, which is also a burst counter. That register can be cleared, loaded from the external address, stepped by one, or held.

A shared mode input chooses the read timing. In flow-through mode the read word appears in the cycle after the request is clocked in. In pipelined mode it passes through one more output register and appears one cycle later. Each port has an active-low and an active-high enable, which allows several devices to be banked by depth. A deselected cycle neither writes nor drives read data, and its port's output reads zero with the valid flag low. If both ports write the same word in the same cycle, the stored value is undefined.

Top module: `burst_dpram`

## Requirements
- R1: Each port captures its enables, write flag, counter controls, address and write data on its own rising clock edge. A captured write reaches the array by the following edge of that port's clock.
- R2: A word written by either port can be read by both ports, and the later of two writes made in different cycles is the one returned.
- R3: With pipe_mode=0 (flow-through), a selected read captured at edge k shows rvalid=1 and the addressed word on rdata between edge k and edge k+1.
- R4: With pipe_mode=1 (pipelined), a selected read captured at edge k shows rvalid=1 and the addressed word between edge k+1 and edge k+2.
- R5: load=1 sets the address register to the addr input.
- R6: step=1 raises the address register by one and ignores the addr input. It wraps from 2^ADDR_W-1 to 0.
- R7: zero=1 sets the address register to 0.
- R8: zero has priority over load, and load has priority over step. With none of the three asserted, the address register holds.
- R9: A port is selected only when sel_n=0 and sel=1 at the edge. A deselected cycle writes nothing and yields rvalid=0 and rdata=0, while the address register still obeys zero, load and step.
- R10: In pipelined mode, after one or more deselected cycles, the output stays off until the edge that follows the first selected read cycle.
- R11: A write cycle yields rvalid=0 and rdata=0 in the output slot it owns.
- R12: After reset both ports show rvalid=0 and rdata=0, and both address registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| pipe_mode | input | 1 | 1 = pipelined read, 0 = flow-through read |
| a_sel_n | input | 1 | Port A active-low enable |
| a_sel | input | 1 | Port A active-high enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_load | input | 1 | Port A load address register from a_addr |
| a_step | input | 1 | Port A advance address register |
| a_zero | input | 1 | Port A clear address register |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| b_sel_n | input | 1 | Port B active-low enable |
| b_sel | input | 1 | Port B active-high enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_load | input | 1 | Port B load address register from b_addr |
| b_step | input | 1 | Port B advance address register |
| b_zero | input | 1 | Port B clear address register |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8, so the array has only sixteen words. This puts the wrap of the burst counter from word 15 to word 0 within a single step. The small array also lets every word written by one port be read back quickly through the other. The two clocks share a period but are offset in phase, which exercises the ownership tags that pick the newest writer across domains. The pipelined checks switch the shared mode input while port A sits deselected, so the reactivation delay becomes visible.

// File: rtl/burst_dpram_pkg.sv
package burst_dpram_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2,
    OP_ZERO = 2'd3
  } cnt_op_e;

  // zero beats load, load beats step (R8)
  function automatic cnt_op_e pick_op(input logic zero, input logic load, input logic step);
    if (zero)      return OP_ZERO;
    else if (load) return OP_LOAD;
    else if (step) return OP_STEP;
    else           return OP_HOLD;
  endfunction

endpackage

// File: rtl/burst_dpram_store.sv
module burst_dpram_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              we_a,
  input  logic [DATA_W-1:0] wd_a,
  output logic [DATA_W-1:0] rd_a,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              we_b,
  input  logic [DATA_W-1:0] wd_b,
  output logic [DATA_W-1:0] rd_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  // tags equal -> bank_a holds newest word, differ -> bank_b
  logic [DEPTH-1:0]  tag_a;
  logic [DEPTH-1:0]  tag_b;

  always_ff @(posedge clk_a) begin
    if (we_a) bank_a[addr_a] <= wd_a;
  end

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n)  tag_a <= '0;
    else if (we_a) tag_a[addr_a] <= tag_b[addr_a];
  end

  always_ff @(posedge clk_b) begin
    if (we_b) bank_b[addr_b] <= wd_b;
  end

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n)  tag_b <= '0;
    else if (we_b) tag_b[addr_b] <= ~tag_a[addr_b];
  end

  always_comb begin
    rd_a = (tag_a[addr_a] == tag_b[addr_a]) ? bank_a[addr_a] : bank_b[addr_a];
    rd_b = (tag_a[addr_b] == tag_b[addr_b]) ? bank_a[addr_b] : bank_b[addr_b];
  end

endmodule

// File: rtl/burst_dpram_port.sv
module burst_dpram_port
  import burst_dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              we,
  input  logic              load,
  input  logic              step,
  input  logic              zero,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              srst_n,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_we,
  output logic [DATA_W-1:0] m_wd,
  input  logic [DATA_W-1:0] m_rd,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [1:0]        sync_q;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic              wd_en;
  logic              rd_now;
  logic              pv_q;
  logic [DATA_W-1:0] pd_q, pd_d;
  cnt_op_e           op;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  // next state
  always_comb begin
    op    = pick_op(zero, load, step);
    act_d = ~sel_n & sel;
    wd_en = act_d & we;
    unique case (op)
      OP_ZERO: cnt_d = '0;
      OP_LOAD: cnt_d = addr;
      OP_STEP: cnt_d = cnt_q + 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // input registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      we_q  <= we;
    end
  end

  always_ff @(posedge clk) begin
    if (wd_en) wd_q <= wdata;
  end

  assign m_addr = cnt_q;
  assign m_we   = act_q & we_q;
  assign m_wd   = wd_q;
  assign rd_now = act_q & ~we_q;

  // output register for pipelined mode
  always_comb pd_d = rd_now ? m_rd : '0;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pv_q <= 1'b0;
      pd_q <= '0;
    end else begin
      pv_q <= rd_now;
      pd_q <= pd_d;
    end
  end

  always_comb begin
    if (pipe_mode) begin
      rvalid = pv_q;
      rdata  = pd_q;
    end else begin
      rvalid = rd_now;
      rdata  = rd_now ? m_rd : '0;
    end
  end

  p_load_addr_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (!zero && load) |=> (m_addr == $past(addr)));

  p_step_wrap_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!zero && !load && step) |=> (m_addr == $past(m_addr) + 1'b1));

  p_zero_addr_r7: assert property (@(posedge clk) disable iff (!srst_n)
    zero |=> (m_addr == '0));

  p_hold_addr_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!zero && !load && !step) |=> $stable(m_addr));

  p_desel_nowr_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !(~sel_n & sel) |=> !m_we);

  p_quiet_data_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !rvalid |-> (rdata == '0));

  p_pipe_off_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !(~sel_n & sel) |=> ##1 (!pipe_mode || !rvalid));

  p_write_quiet_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (!pipe_mode && m_we) |-> !rvalid);

endmodule

// File: rtl/burst_dpram.sv
module burst_dpram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              a_sel_n,
  input  logic              a_sel,
  input  logic              a_we,
  input  logic              a_load,
  input  logic              a_step,
  input  logic              a_zero,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_sel_n,
  input  logic              b_sel,
  input  logic              b_we,
  input  logic              b_load,
  input  logic              b_step,
  input  logic              b_zero,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);

  logic              sr_a_n, sr_b_n;
  logic [ADDR_W-1:0] ma_addr, mb_addr;
  logic              ma_we, mb_we;
  logic [DATA_W-1:0] ma_wd, mb_wd, ma_rd, mb_rd;

  burst_dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pa (
    .clk(clk_a), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .sel_n(a_sel_n), .sel(a_sel), .we(a_we),
    .load(a_load), .step(a_step), .zero(a_zero),
    .addr(a_addr), .wdata(a_wdata), .srst_n(sr_a_n),
    .m_addr(ma_addr), .m_we(ma_we), .m_wd(ma_wd), .m_rd(ma_rd),
    .rdata(a_rdata), .rvalid(a_rvalid)
  );

  burst_dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pb (
    .clk(clk_b), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .sel_n(b_sel_n), .sel(b_sel), .we(b_we),
    .load(b_load), .step(b_step), .zero(b_zero),
    .addr(b_addr), .wdata(b_wdata), .srst_n(sr_b_n),
    .m_addr(mb_addr), .m_we(mb_we), .m_wd(mb_wd), .m_rd(mb_rd),
    .rdata(b_rdata), .rvalid(b_rvalid)
  );

  burst_dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_a(clk_a), .rst_a_n(sr_a_n), .addr_a(ma_addr), .we_a(ma_we),
    .wd_a(ma_wd), .rd_a(ma_rd),
    .clk_b(clk_b), .rst_b_n(sr_b_n), .addr_b(mb_addr), .we_b(mb_we),
    .wd_b(mb_wd), .rd_b(mb_rd)
  );

endmodule

// File: tb/sim_burst_dpram.sv
module sim_burst_dpram;

  localparam int AW = 4;
  localparam int DW = 8;

  logic clk_a, clk_b, rst_n, pipe_mode;
  logic a_sel_n, a_sel, a_we, a_load, a_step, a_zero;
  logic b_sel_n, b_sel, b_we, b_load, b_step, b_zero;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  burst_dpram #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  initial clk_a = 1'b0;
  always #10 clk_a = ~clk_a;
  initial begin
    clk_b = 1'b0;
    #7;
    forever #10 clk_b = ~clk_b;
  end

  typedef struct packed {
    logic          sn, s, w, l, st, z;
    logic [AW-1:0] ad;
    logic [DW-1:0] wd;
    logic          ev;
    logic [DW-1:0] ed;
    logic [7:0]    req;
  } vec_t;

  // flow-through sequence on port A; req = requirement number
  localparam vec_t VEC [13] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd7,  8'h33, 1'b0, 8'h00, 8'd12},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd0,  8'h00, 1'b1, 8'h33, 8'd12},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 4'd15, 8'h44, 1'b0, 8'h00, 8'd11},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 4'd9,  8'h55, 1'b0, 8'h00, 8'd6},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 4'd15, 8'h00, 1'b1, 8'h44, 8'd5},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 4'd3,  8'h00, 1'b1, 8'h55, 8'd6},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1, 4'd15, 8'h00, 1'b1, 8'h55, 8'd8},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 4'd15, 8'h00, 1'b1, 8'h44, 8'd8},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd0,  8'h00, 1'b1, 8'h44, 8'd8},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 4'd0,  8'h00, 1'b0, 8'h00, 8'd9},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 4'd15, 8'h99, 1'b0, 8'h00, 8'd9},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 4'd0,  8'h00, 1'b1, 8'h44, 8'd9},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 4'd0,  8'h00, 1'b1, 8'h55, 8'd7}
  };

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic a_cyc(input logic sn, s, w, l, st, z, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    a_sel_n = sn; a_sel = s; a_we = w; a_load = l; a_step = st; a_zero = z;
    a_addr = ad; a_wdata = d;
    @(posedge clk_a);
    @(negedge clk_a);
  endtask

  task automatic b_cyc(input logic sn, s, w, l, st, z, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    b_sel_n = sn; b_sel = s; b_we = w; b_load = l; b_step = st; b_zero = z;
    b_addr = ad; b_wdata = d;
    @(posedge clk_b);
    @(negedge clk_b);
  endtask

  initial begin
    repeat (20000) @(posedge clk_a);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pipe_mode = 1'b0;
    a_sel_n = 1'b1; a_sel = 1'b0; a_we = 1'b0; a_load = 1'b0; a_step = 1'b0; a_zero = 1'b0;
    a_addr = '0; a_wdata = '0;
    b_sel_n = 1'b1; b_sel = 1'b0; b_we = 1'b0; b_load = 1'b0; b_step = 1'b0; b_zero = 1'b0;
    b_addr = '0; b_wdata = '0;
    repeat (3) @(negedge clk_a);
    chk("R12 a reset", {a_rvalid, a_rdata}, 9'h000);
    chk("R12 b reset", {b_rvalid, b_rdata}, 9'h000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_a);
    chk("R12 a after release", {a_rvalid, a_rdata}, 9'h000);
    chk("R12 b after release", {b_rvalid, b_rdata}, 9'h000);

    // R3 flow-through table walk
    for (int i = 0; i < 13; i++) begin
      a_cyc(VEC[i].sn, VEC[i].s, VEC[i].w, VEC[i].l, VEC[i].st, VEC[i].z, VEC[i].ad, VEC[i].wd);
      chk($sformatf("R%0d R3 vec%0d", VEC[i].req, i), {a_rvalid, a_rdata}, {VEC[i].ev, VEC[i].ed});
    end
    a_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);

    // R2 cross-port access
    @(negedge clk_b);
    b_cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd15, 8'h00);
    chk("R2 b reads a word", {b_rvalid, b_rdata}, 9'h144);
    b_cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd15, 8'h66);
    chk("R11 b write quiet", {b_rvalid, b_rdata}, 9'h000);
    b_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    b_cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R2 b reads a word 0", {b_rvalid, b_rdata}, 9'h155);
    b_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);

    @(negedge clk_a);
    a_cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd15, 8'h00);
    chk("R2 a reads b word", {a_rvalid, a_rdata}, 9'h166);
    a_cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd15, 8'h77);
    a_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);

    @(negedge clk_b);
    b_cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd15, 8'h00);
    chk("R2 later a write wins", {b_rvalid, b_rdata}, 9'h177);
    b_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);

    // R4 / R10 pipelined read on port A
    @(negedge clk_a);
    pipe_mode = 1'b1;
    a_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R10 pipe idle", {a_rvalid, a_rdata}, 9'h000);
    a_cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R10 pipe not yet driven", {a_rvalid, a_rdata}, 9'h000);
    a_cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd15, 8'h00);
    chk("R4 pipe first word", {a_rvalid, a_rdata}, 9'h155);
    a_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R4 pipe second word", {a_rvalid, a_rdata}, 9'h177);
    a_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R9 pipe deselected", {a_rvalid, a_rdata}, 9'h000);
    a_cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 8'hA5);
    a_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R11 pipe write quiet", {a_rvalid, a_rdata}, 9'h000);
    a_cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 8'h00);
    a_cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R1 pipe reads written word", {a_rvalid, a_rdata}, 9'h1A5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule